// File: doc/BRIEF.md
# Read Burst Transaction Observer

This block sits beside the read half of a memory-mapped bus and watches it without driving anything. Each accepted read request opens a per-ID context that stores the request fields. Read data beats are then steered to the matching context by their ID, so bursts on different IDs can be interleaved beat by beat and can finish in any order. As each beat arrives, the context updates a beat count, a running data signature and the most severe response code seen so far.

When the beat flagged last for an ID arrives, the observer closes that ID's oldest open burst. It presents a one-cycle record with the request fields, the observed beat count, the signature and the worst response. A data beat whose ID has nothing outstanding is reported on a one-cycle flag and then discarded. Downstream checkers or coverage logic can consume the records without any handshake.

Top module: `rd_txn_monitor`

## Requirements
- R1: A request or data beat is taken only on a rising clock edge where both its valid and ready inputs are high and reset is low. Stalled cycles and cycles in reset leave no trace.
- R2: Each ID keeps a queue of up to two outstanding requests. A request accepted on the bus while its ID already holds two is discarded.
- R3: A data beat is joined to the oldest outstanding request whose ID equals the beat's ID, so same-ID requests complete in the order they were accepted.
- R4: Beats of bursts with different IDs may interleave freely, and each burst completes independently of the others.
- R5: A burst closes on the beat with the last flag set for its ID. `rec_valid` is high for exactly the one cycle after that beat's edge, and the request is then released from its queue.
- R6: The record carries the burst's ID and the address, length, size and burst type captured from its request. `rec_beats` equals the number of beats received, counting the last one.
- R7: The signature starts at zero for each burst. For every beat it becomes the previous value rotated left by one bit, XOR the beat data.
- R8: Response codes are OKAY=0, EXOKAY=1, SLVERR=2 and DECERR=3. `rec_resp` is the most severe code across the burst, ranked DECERR > SLVERR > EXOKAY > OKAY.
- R9: A data beat whose ID has no outstanding request raises `orphan` for exactly one cycle after its edge. It produces no record and changes no context.
- R10: While reset is high, `rec_valid` and `orphan` are low, and reset empties every per-ID queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ar_valid | input | 1 | Read request valid (observed) |
| ar_ready | input | 1 | Read request ready (observed) |
| ar_id | input | 2 | Read request ID |
| ar_addr | input | 32 | Read request address |
| ar_len | input | 8 | Beats minus one |
| ar_size | input | 3 | Beat size code |
| ar_burst | input | 2 | Burst type code |
| r_valid | input | 1 | Read data valid (observed) |
| r_ready | input | 1 | Read data ready (observed) |
| r_id | input | 2 | Read data ID |
| r_data | input | 32 | Read data |
| r_resp | input | 2 | Per-beat response code |
| r_last | input | 1 | Last beat of the burst for this ID |
| rec_valid | output | 1 | Completed record present (one cycle) |
| rec_id | output | 2 | Record ID |
| rec_addr | output | 32 | Record address |
| rec_len | output | 8 | Record requested length |
| rec_size | output | 3 | Record size code |
| rec_burst | output | 2 | Record burst type |
| rec_beats | output | 9 | Beats observed |
| rec_sig | output | 32 | Data signature |
| rec_resp | output | 2 | Worst response in the burst |
| orphan | output | 1 | Data beat with no outstanding request (one cycle) |

## Verification
The bench interleaves bursts on two IDs with the shorter one finishing first. A design that matched beats to IDs wrongly would mix signatures or emit records in the wrong order. It also queues two requests on one ID and a third that must be dropped. A broken queue would attach data to the newer address, or it would accept the overflow so that the extra beat would not show up as orphan data. Other cases cover stalled handshakes and handshakes during reset, which would wrongly inflate beat counts or open contexts. Mixed response codes are included to catch a design that reports the last code instead of the worst. An orphan beat followed by a clean burst on the same ID shows whether the dropped beat leaked into the signature.

// File: rtl/rdmon_pkg.sv
package rdmon_pkg;

    parameter int ID_W   = 2;
    parameter int ADDR_W = 32;
    parameter int DATA_W = 32;
    parameter int LEN_W  = 8;

    localparam int N_IDS  = 1 << ID_W;
    localparam int BEAT_W = LEN_W + 1;

    localparam logic [1:0] RESP_OKAY   = 2'd0;
    localparam logic [1:0] RESP_EXOKAY = 2'd1;
    localparam logic [1:0] RESP_SLVERR = 2'd2;
    localparam logic [1:0] RESP_DECERR = 2'd3;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  len;
        logic [2:0]        size;
        logic [1:0]        burst;
    } req_hdr_t;

    typedef struct packed {
        req_hdr_t          hdr;
        logic [BEAT_W-1:0] beats;
        logic [DATA_W-1:0] sig;
        logic [1:0]        resp;
    } burst_ctx_t;

    typedef struct packed {
        logic [ID_W-1:0] id;
        burst_ctx_t      ctx;
    } txn_rec_t;

    // Severity rank, higher is worse.
    function automatic logic [1:0] resp_rank(logic [1:0] code);
        case (code)
            RESP_DECERR: return 2'd3;
            RESP_SLVERR: return 2'd2;
            RESP_EXOKAY: return 2'd1;
            default:     return 2'd0;
        endcase
    endfunction

    function automatic logic [1:0] resp_worst(logic [1:0] a, logic [1:0] b);
        return (resp_rank(b) > resp_rank(a)) ? b : a;
    endfunction

    function automatic logic [DATA_W-1:0] sig_step(logic [DATA_W-1:0] s,
                                                   logic [DATA_W-1:0] d);
        return {s[DATA_W-2:0], s[DATA_W-1]} ^ d;
    endfunction

    function automatic burst_ctx_t ctx_open(req_hdr_t h);
        burst_ctx_t c;
        c.hdr   = h;
        c.beats = '0;
        c.sig   = '0;
        c.resp  = RESP_OKAY;
        return c;
    endfunction

    function automatic burst_ctx_t ctx_step(burst_ctx_t c,
                                            logic [DATA_W-1:0] d,
                                            logic [1:0] r);
        burst_ctx_t n;
        n       = c;
        n.beats = c.beats + 1'b1;
        n.sig   = sig_step(c.sig, d);
        n.resp  = resp_worst(c.resp, r);
        return n;
    endfunction

endpackage

// File: rtl/rdmon_id_queue.sv
module rdmon_id_queue
    import rdmon_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push_i,
    input  req_hdr_t          hdr_i,
    input  logic              beat_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [1:0]        resp_i,
    input  logic              last_i,
    output logic              full_o,
    output logic              busy_o,
    output burst_ctx_t        head_o
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    burst_ctx_t      slots [DEPTH];
    logic [PW-1:0]   rd_ptr, wr_ptr;
    logic [CW-1:0]   used;
    logic            pop, upd;

    assign busy_o = (used != '0);
    assign full_o = (used == CW'(DEPTH));
    assign head_o = slots[rd_ptr];
    assign pop    = beat_i && busy_o && last_i;
    assign upd    = beat_i && busy_o && !last_i;

    function automatic logic [PW-1:0] bump(logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            used   <= '0;
        end else begin
            if (push_i) begin
                slots[wr_ptr] <= ctx_open(hdr_i);
                wr_ptr        <= bump(wr_ptr);
            end
            if (upd) begin
                slots[rd_ptr] <= ctx_step(slots[rd_ptr], data_i, resp_i);
            end
            if (pop) begin
                rd_ptr <= bump(rd_ptr);
            end
            if (push_i && !pop)      used <= used + 1'b1;
            else if (pop && !push_i) used <= used - 1'b1;
        end
    end

    // A push is never offered to a full queue (R2).
    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (rst)
        !(push_i && full_o));

    // After a pop the oldest slot is released (R5).
    assert_release_R5: assert property (@(posedge clk) disable iff (rst)
        (pop && !push_i) |=> (used == $past(used) - 1'b1));

endmodule

// File: rtl/rdmon_rec_reg.sv
module rdmon_rec_reg
    import rdmon_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load_i,
    input  txn_rec_t rec_i,
    input  logic     orphan_i,
    output logic     valid_o,
    output txn_rec_t rec_o,
    output logic     orphan_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o  <= 1'b0;
            orphan_o <= 1'b0;
            rec_o    <= '0;
        end else begin
            valid_o  <= load_i;
            orphan_o <= orphan_i;
            if (load_i) rec_o <= rec_i;
        end
    end

    // A record and an orphan flag never coincide: one beat per cycle (R9).
    assert_orphan_alone_R9: assert property (@(posedge clk) disable iff (rst)
        !(valid_o && orphan_o));

endmodule

// File: rtl/rd_txn_monitor.sv
module rd_txn_monitor
    import rdmon_pkg::*;
#(
    parameter int QDEPTH = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ar_valid,
    input  logic                ar_ready,
    input  logic [ID_W-1:0]     ar_id,
    input  logic [ADDR_W-1:0]   ar_addr,
    input  logic [LEN_W-1:0]    ar_len,
    input  logic [2:0]          ar_size,
    input  logic [1:0]          ar_burst,
    input  logic                r_valid,
    input  logic                r_ready,
    input  logic [ID_W-1:0]     r_id,
    input  logic [DATA_W-1:0]   r_data,
    input  logic [1:0]          r_resp,
    input  logic                r_last,
    output logic                rec_valid,
    output logic [ID_W-1:0]     rec_id,
    output logic [ADDR_W-1:0]   rec_addr,
    output logic [LEN_W-1:0]    rec_len,
    output logic [2:0]          rec_size,
    output logic [1:0]          rec_burst,
    output logic [BEAT_W-1:0]   rec_beats,
    output logic [DATA_W-1:0]   rec_sig,
    output logic [1:0]          rec_resp,
    output logic                orphan
);
    logic       ar_fire, r_fire;
    req_hdr_t   req_hdr;
    logic [N_IDS-1:0] q_full, q_busy;
    burst_ctx_t q_head [N_IDS];

    assign ar_fire = ar_valid && ar_ready && !rst;
    assign r_fire  = r_valid  && r_ready  && !rst;

    always_comb begin
        req_hdr.addr  = ar_addr;
        req_hdr.len   = ar_len;
        req_hdr.size  = ar_size;
        req_hdr.burst = ar_burst;
    end

    for (genvar g = 0; g < N_IDS; g++) begin : g_id
        logic push_g, beat_g;
        assign push_g = ar_fire && (ar_id == ID_W'(g)) && !q_full[g];
        assign beat_g = r_fire  && (r_id  == ID_W'(g));

        rdmon_id_queue #(.DEPTH(QDEPTH)) u_q (
            .clk    (clk),
            .rst    (rst),
            .push_i (push_g),
            .hdr_i  (req_hdr),
            .beat_i (beat_g),
            .data_i (r_data),
            .resp_i (r_resp),
            .last_i (r_last),
            .full_o (q_full[g]),
            .busy_o (q_busy[g]),
            .head_o (q_head[g])
        );
    end

    logic     hit, done, stray;
    txn_rec_t next_rec, out_rec;

    assign hit   = q_busy[r_id];
    assign done  = r_fire && hit && r_last;
    assign stray = r_fire && !hit;

    always_comb begin
        next_rec.id  = r_id;
        next_rec.ctx = ctx_step(q_head[r_id], r_data, r_resp);
    end

    rdmon_rec_reg u_out (
        .clk      (clk),
        .rst      (rst),
        .load_i   (done),
        .rec_i    (next_rec),
        .orphan_i (stray),
        .valid_o  (rec_valid),
        .rec_o    (out_rec),
        .orphan_o (orphan)
    );

    assign rec_id    = out_rec.id;
    assign rec_addr  = out_rec.ctx.hdr.addr;
    assign rec_len   = out_rec.ctx.hdr.len;
    assign rec_size  = out_rec.ctx.hdr.size;
    assign rec_burst = out_rec.ctx.hdr.burst;
    assign rec_beats = out_rec.ctx.beats;
    assign rec_sig   = out_rec.ctx.sig;
    assign rec_resp  = out_rec.ctx.resp;

    // A record follows a handshaked last beat (R5).
    assert_rec_after_last_R5: assert property (@(posedge clk) disable iff (rst)
        rec_valid |-> $past(r_valid && r_ready && r_last));

    // The record's ID is the ID of the closing beat (R6).
    assert_rec_id_R6: assert property (@(posedge clk) disable iff (rst)
        rec_valid |-> (rec_id == $past(r_id)));

    // Worst response is at least as severe as the closing beat's (R8).
    assert_worst_resp_R8: assert property (@(posedge clk) disable iff (rst)
        rec_valid |-> (resp_rank(rec_resp) >= resp_rank($past(r_resp))));

    // An orphan flag follows a real handshake (R9).
    assert_orphan_src_R9: assert property (@(posedge clk) disable iff (rst)
        orphan |-> $past(r_valid && r_ready));

endmodule

// File: tb/rd_txn_monitor_tb.sv
module rd_txn_monitor_tb;
    import rdmon_pkg::*;

    logic clk = 0;
    logic rst = 1;
    always #5 clk = ~clk;

    logic              ar_valid = 0, ar_ready = 0;
    logic [ID_W-1:0]   ar_id = 0;
    logic [ADDR_W-1:0] ar_addr = 0;
    logic [LEN_W-1:0]  ar_len = 0;
    logic [2:0]        ar_size = 0;
    logic [1:0]        ar_burst = 0;
    logic              r_valid = 0, r_ready = 0;
    logic [ID_W-1:0]   r_id = 0;
    logic [DATA_W-1:0] r_data = 0;
    logic [1:0]        r_resp = 0;
    logic              r_last = 0;
    logic              rec_valid, orphan;
    logic [ID_W-1:0]   rec_id;
    logic [ADDR_W-1:0] rec_addr;
    logic [LEN_W-1:0]  rec_len;
    logic [2:0]        rec_size;
    logic [1:0]        rec_burst;
    logic [BEAT_W-1:0] rec_beats;
    logic [DATA_W-1:0] rec_sig;
    logic [1:0]        rec_resp;

    rd_txn_monitor u_dut (
        .clk(clk), .rst(rst),
        .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_id(ar_id), .ar_addr(ar_addr),
        .ar_len(ar_len), .ar_size(ar_size), .ar_burst(ar_burst),
        .r_valid(r_valid), .r_ready(r_ready), .r_id(r_id), .r_data(r_data),
        .r_resp(r_resp), .r_last(r_last),
        .rec_valid(rec_valid), .rec_id(rec_id), .rec_addr(rec_addr), .rec_len(rec_len),
        .rec_size(rec_size), .rec_burst(rec_burst), .rec_beats(rec_beats),
        .rec_sig(rec_sig), .rec_resp(rec_resp), .orphan(orphan)
    );

    typedef struct packed {
        logic [ID_W-1:0]   id;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  len;
        logic [2:0]        size;
        logic [1:0]        burst;
        logic [BEAT_W-1:0] beats;
        logic [DATA_W-1:0] sig;
        logic [1:0]        resp;
    } obs_t;

    obs_t got_q[$];
    int   orphan_cycles = 0;
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   finished = 0;

    // Collect outputs one time unit after each rising edge.
    always @(posedge clk) begin
        #1;
        if (rec_valid)
            got_q.push_back('{rec_id, rec_addr, rec_len, rec_size, rec_burst,
                              rec_beats, rec_sig, rec_resp});
        if (orphan) orphan_cycles++;
    end

    function automatic logic [DATA_W-1:0] nsig(logic [DATA_W-1:0] s, logic [DATA_W-1:0] d);
        return {s[DATA_W-2:0], s[DATA_W-1]} ^ d;
    endfunction

    task automatic check(string req, logic [127:0] act, logic [127:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic expect_rec(string req, obs_t exp);
        n_cmp++;
        if (got_q.size() == 0) begin
            n_bad++;
            $display("FAIL %s actual=no record expected=%h", req, exp);
        end else begin
            obs_t g = got_q.pop_front();
            if (g !== exp) begin
                n_bad++;
                $display("FAIL %s actual=%h expected=%h", req, g, exp);
            end
        end
    endtask

    task automatic send_ar(logic [ID_W-1:0] id, logic [ADDR_W-1:0] a,
                           logic [LEN_W-1:0] l, logic [2:0] s, logic [1:0] b);
        @(negedge clk);
        ar_valid = 1; ar_ready = 1; ar_id = id; ar_addr = a;
        ar_len = l; ar_size = s; ar_burst = b;
        @(negedge clk);
        ar_valid = 0; ar_ready = 0;
    endtask

    task automatic send_r(logic [ID_W-1:0] id, logic [DATA_W-1:0] d,
                          logic [1:0] rs, logic lst);
        @(negedge clk);
        r_valid = 1; r_ready = 1; r_id = id; r_data = d; r_resp = rs; r_last = lst;
        @(negedge clk);
        r_valid = 0; r_ready = 0; r_last = 0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        rst = 1;
        @(negedge clk);
        ar_valid = 1; ar_ready = 1; ar_id = 0; ar_addr = 32'hDEAD0000;
        r_valid = 1; r_ready = 1; r_id = 1; r_last = 1;
        repeat (2) @(negedge clk);
        check("R10 rec_valid low in reset", 128'(rec_valid), 0);
        check("R10 orphan low in reset", 128'(orphan), 0);
        ar_valid = 0; ar_ready = 0; r_valid = 0; r_ready = 0; r_last = 0;
        rst = 0;
        idle(1);
        send_r(0, 32'h1111, RESP_OKAY, 1);
        idle(2);
        check("R1 handshake in reset opened nothing (orphan)", 128'(orphan_cycles), 1);
        check("R1 no record after reset", 128'(got_q.size()), 0);
        orphan_cycles = 0;
    endtask

    task automatic t_single;
        logic [DATA_W-1:0] s = '0;
        send_ar(0, 32'h0000_1000, 8'd3, 3'd2, 2'd1);
        for (int i = 0; i < 4; i++) begin
            logic [DATA_W-1:0] d = 32'hA5A5_0000 + 32'(i * 7);
            s = nsig(s, d);
            send_r(0, d, RESP_OKAY, i == 3);
        end
        idle(2);
        expect_rec("R6 R7 single burst", '{0, 32'h1000, 8'd3, 3'd2, 2'd1, 9'd4, s, RESP_OKAY});
        check("R5 exactly one record", 128'(got_q.size()), 0);
    endtask

    task automatic t_stall;
        logic [DATA_W-1:0] s = '0;
        @(negedge clk);
        ar_valid = 1; ar_ready = 0; ar_id = 1; ar_addr = 32'h7777;
        r_valid = 1; r_ready = 0; r_id = 1; r_data = 32'hFFFF_FFFF; r_last = 1;
        repeat (2) @(negedge clk);
        ar_valid = 0; r_valid = 0; r_last = 0;
        send_ar(1, 32'h0000_2000, 8'd1, 3'd2, 2'd1);
        @(negedge clk);
        r_valid = 1; r_ready = 0; r_id = 1; r_data = 32'h0BAD; r_last = 0;
        @(negedge clk);
        r_valid = 0;
        s = nsig(s, 32'h10); send_r(1, 32'h10, RESP_OKAY, 0);
        s = nsig(s, 32'h20); send_r(1, 32'h20, RESP_OKAY, 1);
        idle(2);
        expect_rec("R1 stalled beats ignored", '{1, 32'h2000, 8'd1, 3'd2, 2'd1, 9'd2, s, RESP_OKAY});
        send_r(1, 32'h30, RESP_OKAY, 1);
        idle(2);
        check("R1 stalled request opened nothing", 128'(orphan_cycles), 1);
        check("R1 no extra record", 128'(got_q.size()), 0);
        orphan_cycles = 0;
    endtask

    task automatic t_interleave;
        logic [DATA_W-1:0] s1 = '0, s2 = '0;
        send_ar(1, 32'h0000_3000, 8'd1, 3'd1, 2'd1);
        send_ar(2, 32'h0000_4000, 8'd2, 3'd2, 2'd2);
        s2 = nsig(s2, 32'h201); send_r(2, 32'h201, RESP_OKAY, 0);
        s1 = nsig(s1, 32'h101); send_r(1, 32'h101, RESP_OKAY, 0);
        s2 = nsig(s2, 32'h202); send_r(2, 32'h202, RESP_OKAY, 0);
        s1 = nsig(s1, 32'h102); send_r(1, 32'h102, RESP_OKAY, 1);
        s2 = nsig(s2, 32'h203); send_r(2, 32'h203, RESP_OKAY, 1);
        idle(2);
        expect_rec("R4 R3 id1 finishes first", '{1, 32'h3000, 8'd1, 3'd1, 2'd1, 9'd2, s1, RESP_OKAY});
        expect_rec("R4 R3 id2 finishes second", '{2, 32'h4000, 8'd2, 3'd2, 2'd2, 9'd3, s2, RESP_OKAY});
    endtask

    task automatic t_same_id;
        logic [DATA_W-1:0] s = '0;
        send_ar(3, 32'h0000_5000, 8'd0, 3'd2, 2'd0);
        send_ar(3, 32'h0000_6000, 8'd1, 3'd2, 2'd1);
        send_r(3, 32'hC0, RESP_OKAY, 1);
        s = nsig(s, 32'hC1); send_r(3, 32'hC1, RESP_OKAY, 0);
        s = nsig(s, 32'hC2); send_r(3, 32'hC2, RESP_OKAY, 1);
        idle(2);
        expect_rec("R3 oldest same-ID first", '{3, 32'h5000, 8'd0, 3'd2, 2'd0, 9'd1, 32'hC0, RESP_OKAY});
        expect_rec("R3 second same-ID next", '{3, 32'h6000, 8'd1, 3'd2, 2'd1, 9'd2, s, RESP_OKAY});
    endtask

    task automatic t_resp;
        logic [DATA_W-1:0] s = '0;
        send_ar(0, 32'h0000_7000, 8'd2, 3'd2, 2'd1);
        s = nsig(s, 32'h1); send_r(0, 32'h1, RESP_EXOKAY, 0);
        s = nsig(s, 32'h2); send_r(0, 32'h2, RESP_SLVERR, 0);
        s = nsig(s, 32'h3); send_r(0, 32'h3, RESP_OKAY, 1);
        idle(2);
        expect_rec("R8 SLVERR outranks later OKAY", '{0, 32'h7000, 8'd2, 3'd2, 2'd1, 9'd3, s, RESP_SLVERR});
        s = '0;
        send_ar(1, 32'h0000_8000, 8'd1, 3'd2, 2'd1);
        s = nsig(s, 32'h4); send_r(1, 32'h4, RESP_DECERR, 0);
        s = nsig(s, 32'h5); send_r(1, 32'h5, RESP_EXOKAY, 1);
        idle(2);
        expect_rec("R8 DECERR is worst", '{1, 32'h8000, 8'd1, 3'd2, 2'd1, 9'd2, s, RESP_DECERR});
        send_ar(2, 32'h0000_9000, 8'd0, 3'd2, 2'd1);
        send_r(2, 32'h6, RESP_EXOKAY, 1);
        idle(2);
        expect_rec("R8 EXOKAY above OKAY", '{2, 32'h9000, 8'd0, 3'd2, 2'd1, 9'd1, 32'h6, RESP_EXOKAY});
    endtask

    task automatic t_overflow;
        send_ar(1, 32'h0000_A000, 8'd0, 3'd2, 2'd1);
        send_ar(1, 32'h0000_B000, 8'd0, 3'd2, 2'd1);
        send_ar(1, 32'h0000_C000, 8'd0, 3'd2, 2'd1);
        send_r(1, 32'hE1, RESP_OKAY, 1);
        send_r(1, 32'hE2, RESP_OKAY, 1);
        send_r(1, 32'hE3, RESP_OKAY, 1);
        idle(2);
        expect_rec("R2 first queued", '{1, 32'hA000, 8'd0, 3'd2, 2'd1, 9'd1, 32'hE1, RESP_OKAY});
        expect_rec("R2 second queued", '{1, 32'hB000, 8'd0, 3'd2, 2'd1, 9'd1, 32'hE2, RESP_OKAY});
        check("R2 third request discarded", 128'(got_q.size()), 0);
        check("R2 third beat orphaned", 128'(orphan_cycles), 1);
        orphan_cycles = 0;
    endtask

    task automatic t_orphan;
        send_r(2, 32'hBEEF, RESP_SLVERR, 0);
        idle(2);
        check("R9 orphan one cycle", 128'(orphan_cycles), 1);
        check("R9 orphan gives no record", 128'(got_q.size()), 0);
        send_ar(2, 32'h0000_D000, 8'd0, 3'd2, 2'd1);
        send_r(2, 32'h55, RESP_OKAY, 1);
        idle(2);
        expect_rec("R9 dropped beat left no trace", '{2, 32'hD000, 8'd0, 3'd2, 2'd1, 9'd1, 32'h55, RESP_OKAY});
        orphan_cycles = 0;
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        t_reset();
        t_single();
        t_stall();
        t_interleave();
        t_same_id();
        t_resp();
        t_overflow();
        t_orphan();
        idle(2);
        finish_run();
    end

endmodule